// File: doc/BRIEF.md
# Wide-bus to narrow-slave AHB data width adapter

This block is glue logic placed in front of an unmodified 32-bit AHB slave so that the slave can sit on a 64-bit AHB data bus. Address and control signals go to the slave unchanged. The write data the slave sees is one 32-bit lane of the wide write bus. That lane is picked from the address of the transfer. The slave's 32-bit read data is copied onto every lane of the wide read bus, so a master that reads from either half gets the correct word.

The lane is chosen while the address phase is accepted. It is stored in a register and applied to the write data during the following data phase. Wait states do not disturb the stored lane. A transfer whose size is wider than the slave's data path is not passed to the slave. The adapter answers it with the standard two-cycle AHB ERROR response. All other transfers get the slave's own ready and response signals unchanged.

Top module: `ahb_wadapt`

## Requirements
- R1: A transfer is accepted when `hsel_i`, `hready_i` and `htrans_i[1]` are all high (htrans 2'b10 NONSEQ or 2'b11 SEQ). In the data phase that follows, `s_hwdata_o` carries `hwdata_i[63:32]` if `haddr_i[2]` was 1 at acceptance, and `hwdata_i[31:0]` if it was 0.
- R2: While `hready_i` is low, the stored lane does not change, even when a new address with the other lane is presented.
- R3: Cycles that do not accept a transfer leave the stored lane unchanged. These are cycles with htrans IDLE (2'b00) or BUSY (2'b01), or with `hsel_i` low.
- R4: `hrdata_o[31:0]` and `hrdata_o[63:32]` both equal `s_hrdata_i`.
- R5: `haddr_i`, `htrans_i`, `hwrite_i`, `hsize_i` and `hready_i` appear unchanged on the matching slave-side outputs in the same cycle.
- R6: A transfer with `hsize_i` above 3'b010 drives `s_hsel_o` low. The adapter then answers with `hreadyout_o`=0 and `hresp_o`=1 in the first data-phase cycle, and with `hreadyout_o`=1 and `hresp_o`=1 in the second.
- R7: Outside an ERROR response, `hreadyout_o` and `hresp_o` equal `s_hreadyout_i` and `s_hresp_i`.
- R8: After reset, the stored lane is the lower lane (`s_hwdata_o` = `hwdata_i[31:0]`) and no ERROR response is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Slave select from the decoder |
| haddr_i | input | ADDR_W | Transfer address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write when high |
| hsize_i | input | 3 | Transfer size, log2 of bytes |
| hready_i | input | 1 | Bus-wide ready |
| hwdata_i | input | WIDE_W | Wide write data |
| hrdata_o | output | WIDE_W | Wide read data, slave word replicated |
| hreadyout_o | output | 1 | Ready toward the bus |
| hresp_o | output | 1 | Response toward the bus, 1 = ERROR |
| s_hsel_o | output | 1 | Select to the narrow slave |
| s_haddr_o | output | ADDR_W | Address to the slave |
| s_htrans_o | output | 2 | Transfer type to the slave |
| s_hwrite_o | output | 1 | Direction to the slave |
| s_hsize_o | output | 3 | Size to the slave |
| s_hready_o | output | 1 | Bus ready to the slave |
| s_hwdata_o | output | NARROW_W | Selected write lane |
| s_hrdata_i | input | NARROW_W | Slave read data |
| s_hreadyout_i | input | 1 | Slave ready |
| s_hresp_i | input | 1 | Slave response |

## Verification
The bench uses the default widths, 64 bits on the bus side and 32 on the slave side, so address bit 2 picks the lane. A 64-byte behavioural slave and a byte-array reference make a full sweep possible. Every aligned byte, halfword and word position in both lanes of sixteen words is written, with 0 to 2 wait states. Every word is then read back and compared on both halves of the read bus. During wait states the master presents the opposite lane, and every oversize code from 3 to 7 is sent to the error path.

// File: rtl/ahb_wadapt_pkg.sv
package ahb_wadapt_pkg;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [1:0] HTRANS_SEQ    = 2'b11;

  typedef enum logic [1:0] {
    ERR_IDLE   = 2'd0,
    ERR_FIRST  = 2'd1,
    ERR_SECOND = 2'd2
  } err_state_e;

  function automatic logic xfer_active(logic [1:0] htrans);
    return (htrans == HTRANS_NONSEQ) || (htrans == HTRANS_SEQ);
  endfunction
endpackage

// File: rtl/ahb_wadapt_lane.sv
module ahb_wadapt_lane #(
  parameter int LANE_BITS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic [LANE_BITS-1:0] lane_i,
  output logic [LANE_BITS-1:0] lane_o
);
  logic [LANE_BITS-1:0] lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lane_q <= '0;
    else if (accept_i) lane_q <= lane_i;
  end

  assign lane_o = lane_q;
endmodule

// File: rtl/ahb_wadapt_err.sv
module ahb_wadapt_err
  import ahb_wadapt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic err_active_o,
  output logic err_wait_o
);
  err_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ERR_IDLE:   if (start_i) state_d = ERR_FIRST;
      ERR_FIRST:  state_d = ERR_SECOND;
      ERR_SECOND: state_d = start_i ? ERR_FIRST : ERR_IDLE;
      default:    state_d = ERR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ERR_IDLE;
    else         state_q <= state_d;
  end

  assign err_active_o = (state_q != ERR_IDLE);
  assign err_wait_o   = (state_q == ERR_FIRST);
endmodule

// File: rtl/ahb_wadapt_wmux.sv
module ahb_wadapt_wmux #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int LANES     = WIDE_W / NARROW_W,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [WIDE_W-1:0]    wide_i,
  input  logic [LANE_BITS-1:0] sel_i,
  output logic [NARROW_W-1:0]  narrow_o
);
  logic [NARROW_W-1:0] lane_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = wide_i[g*NARROW_W +: NARROW_W];
  end

  assign narrow_o = lane_w[sel_i];
endmodule

// File: rtl/ahb_wadapt_rrep.sv
module ahb_wadapt_rrep #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int LANES = WIDE_W / NARROW_W
) (
  input  logic [NARROW_W-1:0] narrow_i,
  output logic [WIDE_W-1:0]   wide_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_copy
    assign wide_o[g*NARROW_W +: NARROW_W] = narrow_i;
  end
endmodule

// File: rtl/ahb_wadapt.sv
module ahb_wadapt
  import ahb_wadapt_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 32,
  localparam int LANES       = WIDE_W / NARROW_W,
  localparam int LANE_BITS   = $clog2(LANES),
  localparam int LANE_LSB    = $clog2(NARROW_W / 8),
  localparam logic [2:0] NARROW_SIZE = 3'(LANE_LSB)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hsel_i,
  input  logic [ADDR_W-1:0]   haddr_i,
  input  logic [1:0]          htrans_i,
  input  logic                hwrite_i,
  input  logic [2:0]          hsize_i,
  input  logic                hready_i,
  input  logic [WIDE_W-1:0]   hwdata_i,
  output logic [WIDE_W-1:0]   hrdata_o,
  output logic                hreadyout_o,
  output logic                hresp_o,
  output logic                s_hsel_o,
  output logic [ADDR_W-1:0]   s_haddr_o,
  output logic [1:0]          s_htrans_o,
  output logic                s_hwrite_o,
  output logic [2:0]          s_hsize_o,
  output logic                s_hready_o,
  output logic [NARROW_W-1:0] s_hwdata_o,
  input  logic [NARROW_W-1:0] s_hrdata_i,
  input  logic                s_hreadyout_i,
  input  logic                s_hresp_i
);
  logic                 accept_w, oversize_w;
  logic                 err_active_w, err_wait_w;
  logic [LANE_BITS-1:0] lane_w;

  assign accept_w   = hsel_i & hready_i & xfer_active(htrans_i);
  assign oversize_w = (hsize_i > NARROW_SIZE);

  ahb_wadapt_lane #(.LANE_BITS(LANE_BITS)) u_lane (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept_w),
    .lane_i   (haddr_i[LANE_LSB +: LANE_BITS]),
    .lane_o   (lane_w)
  );

  ahb_wadapt_err u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept_w & oversize_w),
    .err_active_o (err_active_w),
    .err_wait_o   (err_wait_w)
  );

  ahb_wadapt_wmux #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_wmux (
    .wide_i   (hwdata_i),
    .sel_i    (lane_w),
    .narrow_o (s_hwdata_o)
  );

  ahb_wadapt_rrep #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rrep (
    .narrow_i (s_hrdata_i),
    .wide_o   (hrdata_o)
  );

  // oversize transfers never reach the slave
  assign s_hsel_o   = hsel_i & ~oversize_w;
  assign s_haddr_o  = haddr_i;
  assign s_htrans_o = htrans_i;
  assign s_hwrite_o = hwrite_i;
  assign s_hsize_o  = hsize_i;
  assign s_hready_o = hready_i;

  assign hreadyout_o = err_active_w ? ~err_wait_w : s_hreadyout_i;
  assign hresp_o     = err_active_w | s_hresp_i;
endmodule

// File: rtl/ahb_wadapt_chk.sv
module ahb_wadapt_chk #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 32,
  localparam int LANES     = WIDE_W / NARROW_W,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int LANE_LSB  = $clog2(NARROW_W / 8)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hsel_i,
  input logic [ADDR_W-1:0]   haddr_i,
  input logic [1:0]          htrans_i,
  input logic [2:0]          hsize_i,
  input logic                hready_i,
  input logic [WIDE_W-1:0]   hwdata_i,
  input logic                hreadyout_o,
  input logic                hresp_o,
  input logic                s_hsel_o,
  input logic [NARROW_W-1:0] s_hwdata_o,
  input logic                s_hreadyout_i
);
  logic acc_ok, acc_big;
  assign acc_ok  = hsel_i && hready_i && htrans_i[1] && (hsize_i <= 3'(LANE_LSB));
  assign acc_big = hsel_i && hready_i && htrans_i[1] && (hsize_i > 3'(LANE_LSB));

  assert_lane_apply_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> s_hwdata_o ==
      hwdata_i[$past(haddr_i[LANE_LSB +: LANE_BITS]) * NARROW_W +: NARROW_W]);

  assert_lane_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> (!$stable(hwdata_i) || $stable(s_hwdata_o)));

  assert_err_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsize_i > 3'(LANE_LSB)) |-> !s_hsel_o);

  assert_err_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_big |=> (!hreadyout_o && hresp_o));

  assert_err_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hreadyout_o && hresp_o && s_hreadyout_i) |=> (hreadyout_o && hresp_o));

  assert_ready_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreadyout_o != s_hreadyout_i) |-> hresp_o);
endmodule

bind ahb_wadapt ahb_wadapt_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_ahb_wadapt.sv
`timescale 1ns/1ps
module sim_ahb_wadapt;
  localparam int  WIDE_W = 64, NARROW_W = 32, ADDR_W = 32;
  localparam time CLK_P  = 8ns;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic              hsel = 1'b0, hwrite = 1'b0;
  logic [ADDR_W-1:0] haddr = '0;
  logic [1:0]        htrans = 2'b00;
  logic [2:0]        hsize = 3'd2;
  logic [WIDE_W-1:0] hwdata = '0;
  logic              hready;
  logic [WIDE_W-1:0] hrdata;
  logic              hreadyout, hresp;
  logic              s_hsel, s_hwrite, s_hready;
  logic [ADDR_W-1:0] s_haddr;
  logic [1:0]        s_htrans;
  logic [2:0]        s_hsize;
  logic [31:0]       s_hwdata, s_hrdata;
  logic              s_hreadyout;

  assign hready = hreadyout;

  ahb_wadapt #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .hready_i(hready), .hwdata_i(hwdata),
    .hrdata_o(hrdata), .hreadyout_o(hreadyout), .hresp_o(hresp),
    .s_hsel_o(s_hsel), .s_haddr_o(s_haddr), .s_htrans_o(s_htrans), .s_hwrite_o(s_hwrite),
    .s_hsize_o(s_hsize), .s_hready_o(s_hready), .s_hwdata_o(s_hwdata),
    .s_hrdata_i(s_hrdata), .s_hreadyout_i(s_hreadyout), .s_hresp_i(1'b0)
  );

  // behavioural 32-bit slave, 16 words, programmable wait states
  logic [31:0] smem [16];
  logic        d_act, d_wr;
  logic [3:0]  d_idx;
  logic [1:0]  d_ofs;
  logic [2:0]  d_sz;
  int          wcnt, waits_cfg = 0;

  assign s_hreadyout = !d_act || (wcnt == 0);
  assign s_hrdata    = smem[d_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) smem[i] <= '0;
      d_act <= 1'b0; d_wr <= 1'b0; d_idx <= '0; d_ofs <= '0; d_sz <= '0; wcnt <= 0;
    end else begin
      if (d_act && s_hready) begin
        if (d_wr)
          for (int b = 0; b < 4; b++)
            if (b >= int'(d_ofs) && b < int'(d_ofs) + (1 << d_sz))
              smem[d_idx][8*b +: 8] <= s_hwdata[8*b +: 8];
        d_act <= 1'b0;
      end else if (d_act && wcnt > 0) wcnt <= wcnt - 1;
      if (s_hsel && s_hready && s_htrans[1]) begin
        d_act <= 1'b1; d_wr <= s_hwrite; d_idx <= s_haddr[5:2];
        d_ofs <= s_haddr[1:0]; d_sz <= s_hsize; wcnt <= waits_cfg;
      end
    end
  end

  logic [7:0] ref_mem [64];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [5:0] a, input logic wr, input logic [2:0] sz,
                      input logic [63:0] wd, input int waits, output logic [63:0] rd);
    logic [31:0] exp_lane;
    exp_lane = a[2] ? wd[63:32] : wd[31:0];
    rd = '0;
    @(negedge clk);
    haddr = {26'd0, a}; hsel = 1'b1; htrans = 2'b10; hwrite = wr; hsize = sz; waits_cfg = waits;
    #1;
    chk(s_haddr == haddr && s_htrans == htrans && s_hwrite == hwrite && s_hsize == hsize
        && s_hready == hready && s_hsel, "R5 pass-through",
        {s_haddr, 25'd0, s_htrans, s_hwrite, s_hsize, s_hready}, {haddr, 25'd0, htrans, hwrite, hsize, hready});
    @(negedge clk);
    hwdata = wd;
    forever begin
      if (hreadyout) begin
        hsel = 1'b0; htrans = 2'b00;
      end else begin
        // present the opposite lane during wait states
        hsel = 1'b1; htrans = 2'b10; haddr = {26'd0, a ^ 6'd4};
      end
      #1;
      if (wr) chk(s_hwdata == exp_lane, hreadyout ? "R1 write lane" : "R2 lane held in wait",
                  {32'd0, s_hwdata}, {32'd0, exp_lane});
      if (hreadyout) begin
        rd = hrdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic err_probe(input logic [2:0] sz);
    @(negedge clk);
    haddr = 32'h4; hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = sz;
    #1 chk(!s_hsel, "R6 slave select blocked", {63'd0, s_hsel}, 64'd0);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hsize = 3'd2;
    chk(!hreadyout && hresp, "R6 first error cycle", {62'd0, hreadyout, hresp}, 64'd1);
    @(negedge clk);
    chk(hreadyout && hresp, "R6 second error cycle", {62'd0, hreadyout, hresp}, 64'd3);
    @(negedge clk);
    chk(hreadyout && !hresp, "R7 slave response restored", {62'd0, hreadyout, hresp}, 64'd2);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] rd, wd;
    logic [31:0] v, expw, pat;
    int n = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
    hwdata = 64'h1111_2222_3333_4444;
    repeat (3) @(negedge clk);
    #1;
    chk(s_hwdata == 32'h3333_4444, "R8 reset lane", {32'd0, s_hwdata}, 64'h3333_4444);
    chk(hreadyout && !hresp, "R8 reset response", {62'd0, hreadyout, hresp}, 64'd2);
    @(negedge clk) rst_n = 1'b1;

    // write sweep: every aligned byte, half and word in both lanes
    for (int w = 0; w < 16; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          logic [5:0] a;
          a  = 6'(w * 4 + off);
          v  = 32'(w * 32'h0103_0507) ^ 32'(off << 12) ^ 32'(sz * 32'h2468_0000) ^ 32'h5A00_00C3;
          wd = {32'hDEAD_0000 | 32'(n), 32'hBEEF_0000 | 32'(n)};
          for (int i = 0; i < (1 << sz); i++) begin
            wd[8 * (int'(a[2:0]) + i) +: 8] = v[8*i +: 8];
            ref_mem[int'(a) + i] = v[8*i +: 8];
          end
          xfer(a, 1'b1, 3'(sz), wd, n % 3, rd);
          n++;
        end

    // read back every word, both halves
    for (int w = 0; w < 16; w++) begin
      expw = {ref_mem[w*4+3], ref_mem[w*4+2], ref_mem[w*4+1], ref_mem[w*4]};
      xfer(6'(w * 4), 1'b0, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, w % 3, rd);
      chk(rd[31:0] == expw, "R4 read low half", {32'd0, rd[31:0]}, {32'd0, expw});
      chk(rd[63:32] == expw, "R4 read high half", {32'd0, rd[63:32]}, {32'd0, expw});
    end

    // non-accepting cycles must not move the lane
    xfer(6'd4, 1'b1, 3'd2, 64'h0000_0001_0000_0002, 0, rd);
    pat = 32'hC0DE_F00D;
    @(negedge clk); hwdata = {pat, ~pat}; hsel = 1'b1; htrans = 2'b00; haddr = 32'h0;
    @(negedge clk); hsel = 1'b0; htrans = 2'b10;
    @(negedge clk); hsel = 1'b1; htrans = 2'b01;
    @(negedge clk); hsel = 1'b0; htrans = 2'b00;
    #1 chk(s_hwdata == pat, "R3 lane unchanged by idle/busy/unselected", {32'd0, s_hwdata}, {32'd0, pat});

    for (int sz = 3; sz < 8; sz++) err_probe(3'(sz));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule